// File: doc/BRIEF.md
# Demand-Woken Key Matrix Scanner

This block reads a switch matrix of drive lines (outputs, active low) and sense lines (inputs, active low, pulled up outside the chip). While no key is down it leaves every drive line low. A closed switch then pulls its sense line low no matter which row it sits on. A single "any sense low" term, taken after a two-stage synchroniser, wakes the block and raises a one-cycle interrupt. Until that happens, no counter and no scan logic changes state.

Once woken, the block walks a single low level across the drive lines, starting at row 0. It waits a settle time on each row, captures the sense lines, and offers every closed switch of that row as a key code on a valid/ready stream, lowest column first. If a walk finds any key, the drive lines are released high for a rescan period (about 10 ms by default, roughly 100 polls per second), and then a new walk starts. If a walk finds nothing, all drive lines go low again and the block goes back to sleep.

The code stream follows valid/ready rules. A code is transferred in a cycle where both valid and ready are high. While valid is high and ready is low, the code is held unchanged and the walk stalls, so no key is lost under back-pressure. Valid never drops without a transfer.

Top module: `key_matrix_scanner`

## Requirements
- R1: During and straight after reset, all drive lines are low, `key_valid_o` is low and `key_irq_o` is low.
- R2: While no sense line reads low, all drive lines stay low and no code is offered. Valid is high only while exactly one drive line is low.
- R3: Each sense input passes a two-flop synchroniser. When the synchronised lines show any low while asleep, the next state starts a walk. `key_irq_o` is high for exactly that first walk cycle.
- R4: A walk drives drive line 0 low first, then 1, 2, up to the last line. Exactly one line is low at a time, and the others are high.
- R5: Each drive line is held for `SETTLE_CYC` cycles (at least 3) before the synchronised sense lines are captured. No code is offered in a cycle where the drive lines changed.
- R6: A captured low on sense line c while drive line r is low gives code r*`NUM_SENSE`+c (r*8+c by default). Codes of one walk come out in ascending order.
- R7: While `key_valid_o` is high and `key_ready_i` is low, `key_valid_o` stays high and `key_code_o` stays stable. The walk does not advance until the transfer happens.
- R8: After a walk that found at least one key, all drive lines are high for `RESCAN_CYC` cycles. A new walk from drive line 0 follows.
- R9: After a walk that found no key, all drive lines return low and the block sleeps until activity is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sense_ni | input | NUM_SENSE | Sense lines, low = switch closed to a low drive line |
| drive_no | output | NUM_DRIVE | Drive lines, low = row selected |
| key_valid_o | output | 1 | Key code offered |
| key_ready_i | input | 1 | Consumer accepts the code |
| key_code_o | output | CODE_W | Key code, row*NUM_SENSE+column |
| key_irq_o | output | 1 | One-cycle pulse on wake from sleep |

## Verification
The assertions take for granted that the consumer never needs valid to drop on its own, and that the sense lines only respond to drive lines through switch closures, so a code can only follow a settled single-row drive. The stimulus models each switch as a wired-AND of its drive line onto a pulled-up sense line, derived combinationally from the outputs. Presses and releases and ready changes are applied away from the clock edge. Ready is dropped only while the bench is willing to wait, so the hold-under-back-pressure property always sees a later transfer.

// File: rtl/kms_pkg.sv
package kms_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_SETTLE = 2'd1,
    ST_EMIT   = 2'd2,
    ST_REST   = 2'd3
  } kms_state_e;
endpackage

// File: rtl/kms_sense_sync.sv
module kms_sense_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  // Reset to "released": pull-ups read high.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/kms_timer.sv
module kms_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/kms_drive_decode.sv
module kms_drive_decode
  import kms_pkg::*;
#(
  parameter int unsigned NUM_DRIVE = 6,
  parameter int unsigned ROW_W     = 3
) (
  input  kms_state_e           state_i,
  input  logic [ROW_W-1:0]     row_i,
  output logic [NUM_DRIVE-1:0] drive_no
);
  for (genvar g = 0; g < NUM_DRIVE; g++) begin : g_line
    always_comb begin
      unique case (state_i)
        ST_SLEEP:           drive_no[g] = 1'b0;
        ST_SETTLE, ST_EMIT: drive_no[g] = (row_i != ROW_W'(g));
        default:            drive_no[g] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/kms_hit_picker.sv
module kms_hit_picker #(
  parameter int unsigned NUM_SENSE = 8,
  parameter int unsigned COL_W     = 3
) (
  input  logic [NUM_SENSE-1:0] hits_i,
  output logic                 any_o,
  output logic [COL_W-1:0]     col_o,
  output logic [NUM_SENSE-1:0] onehot_o
);
  assign any_o = |hits_i;

  // Lowest set column wins, giving ascending code order.
  always_comb begin
    col_o    = '0;
    onehot_o = '0;
    for (int i = NUM_SENSE - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        col_o    = COL_W'(i);
        onehot_o = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
  import kms_pkg::*;
#(
  parameter int unsigned NUM_DRIVE  = 6,
  parameter int unsigned NUM_SENSE  = 8,
  parameter int unsigned SETTLE_CYC = 8,
  parameter int unsigned RESCAN_CYC = 500000,
  parameter int unsigned CODE_W     = $clog2(NUM_DRIVE * NUM_SENSE)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SENSE-1:0] sense_ni,
  output logic [NUM_DRIVE-1:0] drive_no,
  output logic                 key_valid_o,
  input  logic                 key_ready_i,
  output logic [CODE_W-1:0]    key_code_o,
  output logic                 key_irq_o
);
  localparam int unsigned ROW_W   = (NUM_DRIVE > 1) ? $clog2(NUM_DRIVE) : 1;
  localparam int unsigned COL_W   = (NUM_SENSE > 1) ? $clog2(NUM_SENSE) : 1;
  localparam int unsigned CNT_MAX = (SETTLE_CYC > RESCAN_CYC) ? SETTLE_CYC : RESCAN_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [ROW_W-1:0] LAST_ROW   = ROW_W'(NUM_DRIVE - 1);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] RESCAN_LIM = CNT_W'(RESCAN_CYC - 1);

  kms_state_e state_q, state_d;
  logic [ROW_W-1:0]     row_q;
  logic [NUM_SENSE-1:0] hits_q;
  logic                 found_q;
  logic                 irq_q;

  logic [NUM_SENSE-1:0] sense_sync;
  logic                 activity;
  logic                 tmr_done;
  logic                 tmr_run;
  logic                 tmr_clear;
  logic [CNT_W-1:0]     tmr_limit;
  logic                 hit_any;
  logic [COL_W-1:0]     hit_col;
  logic [NUM_SENSE-1:0] hit_onehot;

  kms_sense_sync #(.WIDTH(NUM_SENSE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sense_ni),
    .q_o    (sense_sync)
  );

  // Any-key term: high when any synchronised sense line is low.
  assign activity = ~&sense_sync;

  assign tmr_run   = (state_q == ST_SETTLE) || (state_q == ST_REST);
  assign tmr_limit = (state_q == ST_REST) ? RESCAN_LIM : SETTLE_LIM;
  assign tmr_clear = (state_d != state_q);

  kms_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clear),
    .run_i   (tmr_run),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  kms_hit_picker #(.NUM_SENSE(NUM_SENSE), .COL_W(COL_W)) u_pick (
    .hits_i   (hits_q),
    .any_o    (hit_any),
    .col_o    (hit_col),
    .onehot_o (hit_onehot)
  );

  kms_drive_decode #(.NUM_DRIVE(NUM_DRIVE), .ROW_W(ROW_W)) u_drive (
    .state_i  (state_q),
    .row_i    (row_q),
    .drive_no (drive_no)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SLEEP:  if (activity) state_d = ST_SETTLE;
      ST_SETTLE: if (tmr_done) state_d = ST_EMIT;
      ST_EMIT: begin
        if (!hit_any) begin
          if (row_q != LAST_ROW)  state_d = ST_SETTLE;
          else if (found_q)       state_d = ST_REST;
          else                    state_d = ST_SLEEP;
        end
      end
      ST_REST:   if (tmr_done) state_d = ST_SETTLE;
      default:   state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SLEEP;
      row_q   <= '0;
      hits_q  <= '0;
      found_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_q == ST_SLEEP) && activity;
      unique case (state_q)
        ST_SLEEP: begin
          if (activity) begin
            row_q   <= '0;
            found_q <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (tmr_done) begin
            hits_q  <= ~sense_sync;
            found_q <= found_q | (|(~sense_sync));
          end
        end
        ST_EMIT: begin
          if (hit_any) begin
            if (key_ready_i) hits_q <= hits_q & ~hit_onehot;
          end else if (row_q != LAST_ROW) begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_REST: begin
          if (tmr_done) begin
            row_q   <= '0;
            found_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign key_valid_o = (state_q == ST_EMIT) && hit_any;
  assign key_code_o  = CODE_W'(row_q) * CODE_W'(NUM_SENSE) + CODE_W'(hit_col);
  assign key_irq_o   = irq_q;
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int unsigned NUM_DRIVE = 6,
  parameter int unsigned NUM_SENSE = 8,
  parameter int unsigned CODE_W    = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_DRIVE-1:0] drive_no,
  input logic                 key_valid_o,
  input logic                 key_ready_i,
  input logic [CODE_W-1:0]    key_code_o,
  input logic                 key_irq_o
);
  localparam int unsigned TOTAL = NUM_DRIVE * NUM_SENSE;

  assert_one_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~drive_no) <= 1) || (drive_no == '0));

  assert_quiet_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> ($countones(~drive_no) == 1));

  assert_irq_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_irq_o |=> !key_irq_o);

  assert_irq_from_sleep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_irq_o |-> ($past(drive_no) == '0));

  assert_settle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_no != $past(drive_no)) |-> !key_valid_o);

  assert_code_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> (int'(key_code_o) < TOTAL));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_o && !key_ready_i) |=> (key_valid_o && $stable(key_code_o)));
endmodule

bind key_matrix_scanner kms_checker #(
  .NUM_DRIVE (NUM_DRIVE),
  .NUM_SENSE (NUM_SENSE),
  .CODE_W    (CODE_W)
) u_kms_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .drive_no    (drive_no),
  .key_valid_o (key_valid_o),
  .key_ready_i (key_ready_i),
  .key_code_o  (key_code_o),
  .key_irq_o   (key_irq_o)
);

// File: tb/tb_key_matrix_scanner.sv
module tb_key_matrix_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int ND     = 6;
  localparam int NS     = 8;
  localparam int SETTLE = 4;
  localparam int RESCAN = 40;
  localparam int CW     = $clog2(ND * NS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] sense_n;
  logic [ND-1:0] drive_n;
  logic          valid;
  logic          ready = 1'b1;
  logic [CW-1:0] code;
  logic          irq;

  logic [NS-1:0] pressed [ND];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int irq_count = 0;
  int got_q[$];

  // model state
  logic [ND-1:0] exp_drive = '0;
  logic          exp_valid = 1'b0;
  logic          exp_irq   = 1'b0;
  int            exp_code  = 0;
  logic [NS-1:0] ms1 = '1, ms2 = '1;
  logic [NS-1:0] pre_sense = '1;
  logic          pre_ready = 1'b1;
  logic          model_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  key_matrix_scanner #(
    .NUM_DRIVE(ND), .NUM_SENSE(NS), .SETTLE_CYC(SETTLE), .RESCAN_CYC(RESCAN)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .sense_ni(sense_n), .drive_no(drive_n),
    .key_valid_o(valid), .key_ready_i(ready), .key_code_o(code), .key_irq_o(irq)
  );

  // Switch model: a closed switch ties its sense line to its drive line.
  always_comb begin
    sense_n = '1;
    for (int r = 0; r < ND; r++)
      for (int c = 0; c < NS; c++)
        if (pressed[r][c] && !drive_n[r]) sense_n[c] = 1'b0;
  end

  function automatic logic [NS-1:0] model_sense(input logic [ND-1:0] drv);
    logic [NS-1:0] s = '1;
    for (int r = 0; r < ND; r++)
      for (int c = 0; c < NS; c++)
        if (pressed[r][c] && !drv[r]) s[c] = 1'b0;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Every-cycle comparison and observation away from the clock edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n && model_on) begin
      check(drive_n == exp_drive, "R4 drive lines", int'(drive_n), int'(exp_drive));
      check(valid == exp_valid, "R7 valid", int'(valid), int'(exp_valid));
      check(irq == exp_irq, "R3 irq", int'(irq), int'(exp_irq));
      if (exp_valid && valid) check(int'(code) == exp_code, "R6 code", int'(code), exp_code);
      if (valid && ready) got_q.push_back(int'(code));
      if (irq) irq_count++;
      pre_sense = model_sense(exp_drive);
      pre_ready = ready;
    end
  end

  task automatic tick(output logic [NS-1:0] seen);
    @(posedge clk);
    #1;
    seen = ms2;
    ms2  = ms1;
    ms1  = pre_sense;
  endtask

  // Behavioural reference: sleep, walk, emit, rest.
  initial begin : model
    logic [NS-1:0] seen;
    logic [NS-1:0] hits;
    bit anyf;
    wait (rst_n);
    model_on = 1'b1;
    forever begin
      exp_drive = '0; exp_valid = 0; exp_irq = 0;
      do tick(seen); while (&seen);
      exp_irq = 1'b1;
      forever begin
        anyf = 0;
        for (int r = 0; r < ND; r++) begin
          exp_drive = '1;
          exp_drive[r] = 1'b0;
          for (int k = 0; k < SETTLE; k++) begin
            tick(seen);
            exp_irq = 1'b0;
          end
          hits = ~seen;
          if (hits != 0) anyf = 1;
          while (hits != 0) begin
            int lo = 0;
            for (int c = NS - 1; c >= 0; c--) if (hits[c]) lo = c;
            exp_valid = 1'b1;
            exp_code  = r * NS + lo;
            tick(seen);
            if (pre_ready) hits[lo] = 1'b0;
          end
          exp_valid = 1'b0;
          tick(seen);
        end
        if (!anyf) break;
        exp_drive = '1;
        repeat (RESCAN) tick(seen);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic press(input int r, input int c);
    pressed[r][c] = 1'b1;
  endtask

  task automatic release_all();
    for (int r = 0; r < ND; r++) pressed[r] = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int irq0;
    for (int r = 0; r < ND; r++) pressed[r] = '0;
    repeat (3) @(posedge clk);
    #2;
    check(drive_n == '0, "R1 reset drive", int'(drive_n), 0);
    check(!valid && !irq, "R1 reset outputs", int'({valid, irq}), 0);
    rst_n = 1'b1;

    // R2: nothing pressed, nothing happens
    wait_cyc(60);
    check(drive_n == '0 && irq_count == 0, "R2 sleep", int'(drive_n), 0);

    // Single key, code 2*8+5 = 21
    press(2, 5);
    wait_cyc(30);
    check(got_q.size() >= 1 && got_q[0] == 21, "R6 single code", got_q.size() ? got_q[0] : -1, 21);
    check(irq_count == 1, "R3 one wake pulse", irq_count, 1);
    release_all();
    wait_cyc(200);
    check(drive_n == '0, "R9 back to sleep", int'(drive_n), 0);
    irq0 = irq_count;
    wait_cyc(50);
    check(irq_count == irq0 && drive_n == '0, "R9 stays asleep", irq_count, irq0);

    // Multiple keys in two rows: codes 0, 7, 43 ascending
    got_q.delete();
    press(0, 0); press(0, 7); press(5, 3);
    wait_cyc(45);
    check(got_q.size() >= 3, "R6 multi count", got_q.size(), 3);
    if (got_q.size() >= 3)
      check(got_q[0] == 0 && got_q[1] == 7 && got_q[2] == 43, "R6 multi order",
            got_q[2], 43);
    // R8: held keys rescanned after the rest period
    wait_cyc(2 * (RESCAN + ND * (SETTLE + 3)));
    check(got_q.size() >= 6, "R8 rescan repeats", got_q.size(), 6);
    release_all();
    wait_cyc(250);
    check(drive_n == '0, "R9 sleep after multi", int'(drive_n), 0);

    // Back-pressure: codes 9 and 10, ready held low for a while
    got_q.delete();
    ready = 1'b0;
    press(1, 1); press(1, 2);
    wait_cyc(40);
    check(valid == 1'b1 && code == 6'd9, "R7 held under stall", int'(code), 9);
    check(got_q.size() == 0, "R7 no transfer while stalled", got_q.size(), 0);
    ready = 1'b1;
    wait_cyc(1);
    ready = 1'b0;
    wait_cyc(10);
    check(valid == 1'b1 && code == 6'd10, "R7 second held", int'(code), 10);
    ready = 1'b1;
    wait_cyc(30);
    check(got_q.size() >= 2 && got_q[0] == 9 && got_q[1] == 10, "R7 both delivered",
          got_q.size(), 2);
    release_all();
    wait_cyc(250);
    check(drive_n == '0 && !valid, "R9 final sleep", int'(drive_n), 0);
    check(irq_count == 3, "R3 wake count", irq_count, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule